// File: doc/BRIEF.md
# Load Wait-Bit Independence Predictor

This block keeps one predictor bit for every instruction slot of a 32 KB, 2-way instruction cache with 32-byte lines and 4-byte instructions. That makes 512 sets × 2 ways × 8 slots. The bit tells a load whether it may issue before the addresses of older stores are resolved. A clear bit means the load issues speculatively. A set bit means it waits until every earlier store address is known.

Three sources change the bits:
- The misprediction detector sets the bit of a load that bypassed a store it depended on.
- A line fill clears all slots of the line being replaced, so a new line never inherits the old line's history.
- A free-running timer wipes the whole table once per fixed period, so stale wait marks age out.

Lookups are addressed by cache set, way and slot, and the answer appears one cycle later. The answer reflects the table as it stood before any update made in the same cycle.

Top module: `wait_bit_predictor`

## Requirements
- R1: After reset, and after any later reset, every slot reads as speculate (`rsp_wait` = 0) and `rsp_valid` is 0 while reset is held.
- R2: A lookup presented in cycle t gives `rsp_valid` = 1 in cycle t+1, and `rsp_valid` = 0 otherwise. `rsp_wait` = 1 means wait and 0 means speculate. The answer reflects the table before the updates of cycle t.
- R3: A violation at (set, way, slot) sets only that slot's bit. Other slots of the line, the other way of the set, and other sets are unchanged. The index range covers set 0 through set 511 and way 1.
- R4: Once set, a bit reads as wait on every later lookup until a fill of its line, a periodic wipe, or a reset clears it.
- R5: A fill of (set, way) clears all 8 slots of that line and no other line. Bits that were set in the line before the fill do not reappear when a later violation marks a different slot of that line.
- R6: When a violation and a fill address the same line in the same cycle, the line ends with only the violating slot set.
- R7: The whole table is wiped on the 10,000th clock edge after reset and on every 10,000th edge after that. The bits are still intact on the edge before the wipe. A 14-bit counter that wraps after 9999 times the wipe.
- R8: A violation in the wipe cycle survives the wipe. The other slots of its line and all other lines are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_set | input | 9 | Lookup cache set |
| lk_way | input | 1 | Lookup cache way |
| lk_slot | input | 3 | Lookup instruction slot within the line |
| rsp_valid | output | 1 | Lookup answer valid (one cycle after request) |
| rsp_wait | output | 1 | 1 = wait for older store addresses, 0 = speculate |
| viol_valid | input | 1 | Independence misprediction detected |
| viol_set | input | 9 | Set of the mispredicted load |
| viol_way | input | 1 | Way of the mispredicted load |
| viol_slot | input | 3 | Slot of the mispredicted load |
| fill_valid | input | 1 | New line written into the cache |
| fill_set | input | 9 | Set of the filled line |
| fill_way | input | 1 | Way of the filled line |

## Verification
The situation hardest to reach from the ports is a violation that lands in exactly the cycle the periodic wipe fires. The wipe timer is not visible at the ports, so that cycle cannot be observed directly. The bench counts clock edges from reset release in its own counter. It marks slots early, probes them just before the wipe edge, and then drives a violation aligned to the final cycle of the period. Probes after the wipe show which bits survive. The sequence is repeated for a second period to confirm that the counter wraps.

// File: rtl/wbp_pkg.sv
package wbp_pkg;

  // Origin of the row written on a violation.
  typedef enum logic [1:0] {
    BASE_NONE   = 2'd0,   // no write this cycle
    BASE_STORED = 2'd1,   // stored row is live: OR the new bit in
    BASE_EMPTY  = 2'd2    // row is dead (invalid, filled or wiped): start fresh
  } row_base_e;

  function automatic int unsigned sets_of(input int unsigned cache_bytes,
                                          input int unsigned ways,
                                          input int unsigned line_bytes);
    return cache_bytes / (ways * line_bytes);
  endfunction

  function automatic int unsigned slots_of(input int unsigned line_bytes,
                                           input int unsigned insn_bytes);
    return line_bytes / insn_bytes;
  endfunction

  // True on the last count of a wipe period.
  function automatic logic period_end(input int unsigned cnt,
                                      input int unsigned period);
    return cnt == period - 1;
  endfunction

endpackage

// File: rtl/wbp_sweep_timer.sv
module wbp_sweep_timer #(
  parameter int unsigned PERIOD = 10000,
  parameter int unsigned CNT_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             pulse
);
  import wbp_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  generate
    if (PERIOD > 1) begin : g_count
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_every
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= '0;
      end
    end
  endgenerate

  assign cnt   = cnt_q;
  assign pulse = period_end(int'(cnt_q), PERIOD);

endmodule

// File: rtl/wbp_update_ctrl.sv
module wbp_update_ctrl #(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned SLOT_W = 3
) (
  input  logic              viol_valid,
  input  logic [LINE_W-1:0] viol_line,
  input  logic [SLOT_W-1:0] viol_slot,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              sweep,
  input  logic              stored_vld,
  input  logic [SLOTS-1:0]  stored_row,
  output logic              wr_en,
  output logic [LINE_W-1:0] wr_line,
  output logic [SLOTS-1:0]  wr_row,
  output logic              set_hits_fill,
  output wbp_pkg::row_base_e base
);
  import wbp_pkg::*;

  logic [SLOTS-1:0] slot_bit;

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_dec
      assign slot_bit[s] = (viol_slot == SLOT_W'(s));
    end
  endgenerate

  assign set_hits_fill = viol_valid && fill_valid && (viol_line == fill_line);

  always_comb begin
    if (!viol_valid)                             base = BASE_NONE;
    else if (stored_vld && !sweep && !set_hits_fill) base = BASE_STORED;
    else                                         base = BASE_EMPTY;
  end

  assign wr_en   = (base != BASE_NONE);
  assign wr_line = viol_line;
  assign wr_row  = slot_bit | ((base == BASE_STORED) ? stored_row : '0);

endmodule

// File: rtl/wbp_bit_store.sv
module wbp_bit_store #(
  parameter int unsigned LINES  = 1024,
  parameter int unsigned LINE_W = 10,
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  // write of one row (violation), marks the line live
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [SLOTS-1:0]  wr_row,
  // kill one line (fill)
  input  logic              inv_en,
  input  logic [LINE_W-1:0] inv_line,
  // kill every line (periodic wipe)
  input  logic              flash_clr,
  // combinational read for read-modify-write
  input  logic [LINE_W-1:0] rmw_line,
  output logic              rmw_vld,
  output logic [SLOTS-1:0]  rmw_row,
  // registered lookup
  input  logic              lk_valid,
  input  logic [LINE_W-1:0] lk_line,
  input  logic [SLOT_W-1:0] lk_slot,
  output logic              rsp_valid,
  output logic              rsp_wait
);

  logic [SLOTS-1:0] row_q [LINES];
  logic [LINES-1:0] live_q;

  // Row contents carry no reset: a row is meaningful only while live.
  always_ff @(posedge clk) begin
    if (wr_en) row_q[wr_line] <= wr_row;
  end

  // Priority per line: row write > line kill / flash kill > hold.
  generate
    for (genvar g = 0; g < LINES; g++) begin : g_live
      logic hit_wr, hit_kill;
      assign hit_wr   = wr_en && (wr_line == LINE_W'(g));
      assign hit_kill = flash_clr || (inv_en && (inv_line == LINE_W'(g)));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        live_q[g] <= 1'b0;
        else if (hit_wr)   live_q[g] <= 1'b1;
        else if (hit_kill) live_q[g] <= 1'b0;
      end
    end
  endgenerate

  assign rmw_vld = live_q[rmw_line];
  assign rmw_row = row_q[rmw_line];

  logic [SLOTS-1:0] lk_row;
  logic             lk_live;
  assign lk_row  = row_q[lk_line];
  assign lk_live = live_q[lk_line];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_wait  <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_wait  <= lk_valid && lk_live && lk_row[lk_slot];
    end
  end

endmodule

// File: rtl/wait_bit_predictor.sv
module wait_bit_predictor #(
  parameter int unsigned CACHE_BYTES = 32768,
  parameter int unsigned WAYS        = 2,
  parameter int unsigned LINE_BYTES  = 32,
  parameter int unsigned INSN_BYTES  = 4,
  parameter int unsigned PERIOD      = 10000,
  parameter int unsigned CNT_W       = 14,
  localparam int unsigned SETS   = wbp_pkg::sets_of(CACHE_BYTES, WAYS, LINE_BYTES),
  localparam int unsigned SLOTS  = wbp_pkg::slots_of(LINE_BYTES, INSN_BYTES),
  localparam int unsigned SET_W  = $clog2(SETS),
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [SET_W-1:0]  lk_set,
  input  logic [WAY_W-1:0]  lk_way,
  input  logic [SLOT_W-1:0] lk_slot,
  output logic              rsp_valid,
  output logic              rsp_wait,
  input  logic              viol_valid,
  input  logic [SET_W-1:0]  viol_set,
  input  logic [WAY_W-1:0]  viol_way,
  input  logic [SLOT_W-1:0] viol_slot,
  input  logic              fill_valid,
  input  logic [SET_W-1:0]  fill_set,
  input  logic [WAY_W-1:0]  fill_way
);
  import wbp_pkg::*;

  localparam int unsigned LINE_W = SET_W + WAY_W;
  localparam int unsigned LINES  = SETS * WAYS;

  // Named internal events, observed by the bound checker.
  logic [CNT_W-1:0]  sweep_cnt;
  logic              sweep_pulse;
  logic              set_hits_fill;
  row_base_e         set_base;

  logic [LINE_W-1:0] viol_line, fill_line, lk_line, wr_line;
  logic [SLOTS-1:0]  stored_row, wr_row;
  logic              stored_vld, wr_en;

  assign viol_line = {viol_set, viol_way};
  assign fill_line = {fill_set, fill_way};
  assign lk_line   = {lk_set, lk_way};

  wbp_sweep_timer #(
    .PERIOD (PERIOD),
    .CNT_W  (CNT_W)
  ) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (sweep_cnt),
    .pulse (sweep_pulse)
  );

  wbp_update_ctrl #(
    .LINE_W (LINE_W),
    .SLOTS  (SLOTS),
    .SLOT_W (SLOT_W)
  ) i_ctrl (
    .viol_valid    (viol_valid),
    .viol_line     (viol_line),
    .viol_slot     (viol_slot),
    .fill_valid    (fill_valid),
    .fill_line     (fill_line),
    .sweep         (sweep_pulse),
    .stored_vld    (stored_vld),
    .stored_row    (stored_row),
    .wr_en         (wr_en),
    .wr_line       (wr_line),
    .wr_row        (wr_row),
    .set_hits_fill (set_hits_fill),
    .base          (set_base)
  );

  wbp_bit_store #(
    .LINES  (LINES),
    .LINE_W (LINE_W),
    .SLOTS  (SLOTS),
    .SLOT_W (SLOT_W)
  ) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_line   (wr_line),
    .wr_row    (wr_row),
    .inv_en    (fill_valid),
    .inv_line  (fill_line),
    .flash_clr (sweep_pulse),
    .rmw_line  (viol_line),
    .rmw_vld   (stored_vld),
    .rmw_row   (stored_row),
    .lk_valid  (lk_valid),
    .lk_line   (lk_line),
    .lk_slot   (lk_slot),
    .rsp_valid (rsp_valid),
    .rsp_wait  (rsp_wait)
  );

endmodule

// File: rtl/wbp_checker.sv
module wbp_checker #(
  parameter int unsigned SET_W  = 9,
  parameter int unsigned WAY_W  = 1,
  parameter int unsigned SLOT_W = 3,
  parameter int unsigned PERIOD = 10000,
  parameter int unsigned CNT_W  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [SET_W-1:0]  lk_set,
  input logic [WAY_W-1:0]  lk_way,
  input logic [SLOT_W-1:0] lk_slot,
  input logic              rsp_valid,
  input logic              rsp_wait,
  input logic              viol_valid,
  input logic [SET_W-1:0]  viol_set,
  input logic [WAY_W-1:0]  viol_way,
  input logic [SLOT_W-1:0] viol_slot,
  input logic              fill_valid,
  input logic [SET_W-1:0]  fill_set,
  input logic [WAY_W-1:0]  fill_way,
  input logic              sweep_pulse,
  input logic [CNT_W-1:0]  sweep_cnt
);
  localparam int unsigned AW = SET_W + WAY_W + SLOT_W;
  localparam int unsigned LW = SET_W + WAY_W;

  logic          pv_v, pf_v, ps_v;
  logic [AW-1:0] pv_addr;
  logic [LW-1:0] pf_line;
  logic [31:0]   gap;

  wire [AW-1:0] lk_addr = {lk_set, lk_way, lk_slot};
  wire [LW-1:0] lk_ln   = {lk_set, lk_way};
  wire [LW-1:0] pv_ln   = pv_addr[AW-1:SLOT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_v <= 1'b0; pf_v <= 1'b0; ps_v <= 1'b0;
      pv_addr <= '0; pf_line <= '0; gap <= '0;
    end else begin
      pv_v    <= viol_valid;
      pv_addr <= {viol_set, viol_way, viol_slot};
      pf_v    <= fill_valid;
      pf_line <= {fill_set, fill_way};
      ps_v    <= sweep_pulse;
      gap     <= sweep_pulse ? '0 : gap + 1;
    end
  end

  a_r2_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  a_r2_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_wait);
  a_r4_set_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && pv_v && lk_addr == pv_addr) |=> rsp_wait);
  a_r5_fill_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && pf_v && lk_ln == pf_line && !(pv_v && pv_ln == pf_line)) |=> !rsp_wait);
  a_r7_wipe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && ps_v && !(pv_v && pv_ln == lk_ln)) |=> !rsp_wait);
  a_r7_counter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_cnt < CNT_W'(PERIOD));
  a_r7_wipe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_pulse |-> gap == PERIOD - 1);

endmodule

bind wait_bit_predictor wbp_checker #(
  .SET_W  (SET_W),
  .WAY_W  (WAY_W),
  .SLOT_W (SLOT_W),
  .PERIOD (PERIOD),
  .CNT_W  (CNT_W)
) i_wbp_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_valid    (lk_valid),
  .lk_set      (lk_set),
  .lk_way      (lk_way),
  .lk_slot     (lk_slot),
  .rsp_valid   (rsp_valid),
  .rsp_wait    (rsp_wait),
  .viol_valid  (viol_valid),
  .viol_set    (viol_set),
  .viol_way    (viol_way),
  .viol_slot   (viol_slot),
  .fill_valid  (fill_valid),
  .fill_set    (fill_set),
  .fill_way    (fill_way),
  .sweep_pulse (sweep_pulse),
  .sweep_cnt   (sweep_cnt)
);

// File: tb/test_wait_bit_predictor.sv
`timescale 1ns/1ps
module test_wait_bit_predictor;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lk_valid = 1'b0, viol_valid = 1'b0, fill_valid = 1'b0;
  logic [8:0] lk_set = '0, viol_set = '0, fill_set = '0;
  logic       lk_way = 1'b0, viol_way = 1'b0, fill_way = 1'b0;
  logic [2:0] lk_slot = '0, viol_slot = '0;
  logic       rsp_valid, rsp_wait;

  int checks = 0;
  int fails  = 0;
  int ncyc   = 0;   // clock edges since reset release
  int wd     = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  wait_bit_predictor i_wait_bit_predictor (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_set(lk_set), .lk_way(lk_way), .lk_slot(lk_slot),
    .rsp_valid(rsp_valid), .rsp_wait(rsp_wait),
    .viol_valid(viol_valid), .viol_set(viol_set), .viol_way(viol_way), .viol_slot(viol_slot),
    .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ncyc <= 0; else ncyc <= ncyc + 1;

  typedef struct packed {
    logic [3:0] req;
    logic       dv, df, dl;
    logic [8:0] vs; logic vw; logic [2:0] vo;
    logic [8:0] fs; logic fw;
    logic [8:0] ls; logic lw; logic [2:0] lo;
    logic       exp;
  } vec_t;

  function automatic vec_t mk(int req, int dv, int df, int dl,
                              int vs, int vw, int vo, int fs, int fw,
                              int ls, int lw, int lo, int exp);
    vec_t v;
    v.req = 4'(req); v.dv = 1'(dv); v.df = 1'(df); v.dl = 1'(dl);
    v.vs = 9'(vs); v.vw = 1'(vw); v.vo = 3'(vo);
    v.fs = 9'(fs); v.fw = 1'(fw);
    v.ls = 9'(ls); v.lw = 1'(lw); v.lo = 3'(lo); v.exp = 1'(exp);
    return v;
  endfunction

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    mk(1,0,0,1, 0,0,0, 0,0,   5,0,3, 0),  // R1 fresh table speculates
    mk(3,1,0,0, 5,0,3, 0,0,   0,0,0, 0),
    mk(4,0,0,1, 0,0,0, 0,0,   5,0,3, 1),  // R4
    mk(3,0,0,1, 0,0,0, 0,0,   5,0,2, 0),  // R3 neighbour slot
    mk(3,0,0,1, 0,0,0, 0,0,   5,1,3, 0),  // R3 other way
    mk(3,0,0,1, 0,0,0, 0,0,   4,0,3, 0),  // R3 other set
    mk(2,1,0,1, 5,0,7, 0,0,   5,0,7, 0),  // R2 same-cycle read sees old
    mk(4,0,0,1, 0,0,0, 0,0,   5,0,7, 1),
    mk(2,0,1,1, 0,0,0, 5,0,   5,0,3, 1),  // R2 fill not yet visible
    mk(5,0,0,1, 0,0,0, 0,0,   5,0,3, 0),
    mk(5,0,0,1, 0,0,0, 0,0,   5,0,7, 0),
    mk(3,1,0,0, 9,1,0, 0,0,   0,0,0, 0),
    mk(3,1,0,0, 9,0,0, 0,0,   0,0,0, 0),
    mk(5,0,1,0, 0,0,0, 9,1,   0,0,0, 0),
    mk(5,0,0,1, 0,0,0, 0,0,   9,0,0, 1),  // R5 other way untouched
    mk(5,0,0,1, 0,0,0, 0,0,   9,1,0, 0),
    mk(6,1,0,0, 300,1,5, 0,0, 0,0,0, 0),
    mk(6,1,1,0, 300,1,4, 300,1, 0,0,0, 0),
    mk(6,0,0,1, 0,0,0, 0,0,   300,1,4, 1),  // R6 set wins
    mk(6,0,0,1, 0,0,0, 0,0,   300,1,5, 0),  // R6 rest cleared
    mk(3,1,0,0, 511,1,7, 0,0, 0,0,0, 0),
    mk(3,0,0,1, 0,0,0, 0,0,   511,1,7, 1),  // R3 top index
    mk(3,0,0,1, 0,0,0, 0,0,   0,0,0, 0),
    mk(3,0,0,1, 0,0,0, 0,0,   511,1,6, 0),
    mk(5,1,0,0, 5,0,1, 0,0,   0,0,0, 0),
    mk(5,0,0,1, 0,0,0, 0,0,   5,0,1, 1),
    mk(5,0,0,1, 0,0,0, 0,0,   5,0,3, 0),  // R5 stale bit not revived
    mk(5,0,0,1, 0,0,0, 0,0,   5,0,7, 0)
  };

  task automatic check(input int req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual=%b expected=%b", req, what, got, exp);
    end
  endtask

  // Called at a negedge: drive, step one cycle, release, check answer.
  task automatic run_vec(input vec_t v);
    viol_valid = v.dv; viol_set = v.vs; viol_way = v.vw; viol_slot = v.vo;
    fill_valid = v.df; fill_set = v.fs; fill_way = v.fw;
    lk_valid = v.dl;   lk_set = v.ls;   lk_way = v.lw;   lk_slot = v.lo;
    @(negedge clk);
    viol_valid = 1'b0; fill_valid = 1'b0; lk_valid = 1'b0;
    check(2, "rsp_valid", rsp_valid, v.dl);
    if (v.dl) check(int'(v.req), "rsp_wait", rsp_wait, v.exp);
  endtask

  task automatic wait_edges(input int n);
    while (ncyc < n) @(negedge clk);
  endtask

  task automatic wipe_round(input int base);
    run_vec(mk(7,1,0,0, 20,0,1, 0,0, 0,0,0, 0));
    run_vec(mk(8,1,0,0, 30,1,2, 0,0, 0,0,0, 0));
    wait_edges(base - 3);
    run_vec(mk(7,0,0,1, 0,0,0, 0,0, 20,0,1, 1));   // R7 intact before wipe edge
    wait_edges(base - 1);
    run_vec(mk(8,1,0,0, 30,1,6, 0,0, 0,0,0, 0));   // R8 violation in wipe cycle
    check(7, "edge count at wipe", ncyc == base, 1'b1);
    run_vec(mk(7,0,0,1, 0,0,0, 0,0, 20,0,1, 0));   // R7 wiped
    run_vec(mk(8,0,0,1, 0,0,0, 0,0, 30,1,6, 1));   // R8 survives
    run_vec(mk(8,0,0,1, 0,0,0, 0,0, 30,1,2, 0));   // R8 line mate cleared
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, "rsp_valid in reset", rsp_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    foreach (VECS[i]) run_vec(VECS[i]);
    wipe_round(10000);
    wipe_round(20000);
    // R1: reset again, the surviving bit must be gone
    rst_n = 1'b0;
    @(negedge clk);
    check(1, "rsp_valid in reset", rsp_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    run_vec(mk(1,0,0,1, 0,0,0, 0,0, 30,1,6, 0));
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog (R1..): actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule